// File: doc/BRIEF.md
# Two-Wire Converter Result Reader

This block is the host side of a two-wire serial link to a delta-sigma converter that runs with an externally supplied serial clock and a chip select that stays low. The block drives the serial clock itself and reads the converter's data line. It holds the clock low after reset long enough for the converter to finish its power-on sequence and latch external-clock operation. It then polls the data line, which stays high while a conversion runs, until the line goes low to signal a ready result.

Once a result is ready, the block issues exactly 24 clock pulses. It samples one bit per pulse, most significant first, and the first bit is the converter's ready flag. It presents the word on a parallel output with a one-cycle strobe, split into a 4-bit status field and a 20-bit result field. A programmable length lets the host take the word early after its first N bits. The remaining pulses are still issued, because with chip select tied low, finishing the 24th pulse is the only way to start the next conversion. A sticky flag records any frame whose first sampled bit was not low.

Top module: `sdo_frame_reader`

## Requirements
- R1: After reset, sck_o stays low for PWRUP_CYCLES clock cycles, even when sdo_i is low, and result_valid_o and eoc_err_o are 0.
- R2: While idle, sck_o stays low for as long as sdo_i reads high, and no word is produced.
- R3: Each SCK high phase and each low phase inside a frame lasts H clock cycles. H is DEF_HALF when half_period_i is 0, it is 4 when half_period_i is 1 to 3, and it is half_period_i otherwise.
- R4: sdo_i is sampled once per pulse, at the end of the SCK high phase, and bits are assembled most significant first. Bit 23 is the first sampled bit and bit 0 is the last.
- R5: Every frame issues exactly 24 SCK rising edges and then returns to polling, without a pulse while sdo_i reads high.
- R6: result_valid_o pulses high for one cycle per frame. Alongside it, status_o equals frame_o[23:20] and result_o equals frame_o[19:0].
- R7: When frame_len_i is 1 to 23, the word is published after that many bits. frame_o then holds those bits in its top positions, with the lower bits zero. When frame_len_i is 0 or 24 to 31, the full 24 bits are published. In both cases 24 pulses are issued.
- R8: eoc_err_o is set when the first sampled bit of a frame is 1, and it stays set until reset.
- R9: result_valid_o rises one clock cycle after the SCK falling edge that ends the last published bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sdo_i | input | 1 | Serial data and ready line from the converter |
| half_period_i | input | DIV_W | SCK half-period in clock cycles (0 selects the default) |
| frame_len_i | input | LEN_W | Number of bits to publish (0 or 24 and above means all 24) |
| sck_o | output | 1 | Serial clock to the converter |
| frame_o | output | 24 | Published word, with the first bit at position 23 |
| status_o | output | 4 | Top four bits of the word |
| result_o | output | 20 | Lower twenty bits of the word |
| result_valid_o | output | 1 | One-cycle strobe for a new word |
| eoc_err_o | output | 1 | Sticky flag for a frame whose first bit was high |

## Verification
A converter model reacts to the edges of sck_o. It changes its data one time unit after each falling edge and pushes the expected, length-masked word into a scoreboard queue when it signals ready. The word is due one clock after the SCK falling edge that ends its last published bit, so the monitor samples on falling clock edges and checks that the SCK fall was seen exactly one cycle earlier. Half-period lengths are measured in clock cycles between the first rising and falling SCK edges of each frame, and pulse counts are taken once the model has seen the 24th falling edge.

// File: rtl/sfr_pkg.sv
package sfr_pkg;
  localparam int FRAME_BITS = 24;
  localparam int STAT_BITS  = 4;
  localparam int RES_BITS   = FRAME_BITS - STAT_BITS;
  localparam int CNT_W      = $clog2(FRAME_BITS + 1);

  typedef enum logic [1:0] {
    ST_PWRUP = 2'd0,
    ST_POLL  = 2'd1,
    ST_HI    = 2'd2,
    ST_LO    = 2'd3
  } rd_state_t;
endpackage

// File: rtl/sfr_tick.sv
module sfr_tick #(
  parameter int DIV_W    = 8,
  parameter int MIN_HALF = 4,
  parameter int DEF_HALF = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] half_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] lim;

  always_comb begin
    if (half_i == '0)                       lim = DIV_W'(DEF_HALF - 1);
    else if (half_i < DIV_W'(MIN_HALF))     lim = DIV_W'(MIN_HALF - 1);
    else                                    lim = half_i - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      tick_o <= 1'b0;
    end else if (cnt >= lim) begin
      cnt    <= '0;
      tick_o <= 1'b1;
    end else begin
      cnt    <= cnt + 1'b1;
      tick_o <= 1'b0;
    end
  end

  // R3
  tick_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    tick_o |=> !tick_o);
endmodule

// File: rtl/sfr_shift.sv
module sfr_shift #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr_i,
  input  logic         en_i,
  input  logic         bit_i,
  output logic [W-1:0] data_o
);
  always_ff @(posedge clk) begin
    if (rst || clr_i) data_o <= '0;
    else if (en_i)    data_o <= {data_o[W-2:0], bit_i};
  end

  // R4
  shift_clear_chk: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (data_o == '0));
endmodule

// File: rtl/sdo_frame_reader.sv
module sdo_frame_reader
  import sfr_pkg::*;
#(
  parameter int DIV_W        = 8,
  parameter int LEN_W        = 5,
  parameter int MIN_HALF     = 4,
  parameter int DEF_HALF     = 32,
  parameter int PWRUP_CYCLES = 125000
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  sdo_i,
  input  logic [DIV_W-1:0]      half_period_i,
  input  logic [LEN_W-1:0]      frame_len_i,
  output logic                  sck_o,
  output logic [FRAME_BITS-1:0] frame_o,
  output logic [STAT_BITS-1:0]  status_o,
  output logic [RES_BITS-1:0]   result_o,
  output logic                  result_valid_o,
  output logic                  eoc_err_o
);
  localparam int PW_W = $clog2(PWRUP_CYCLES + 1);

  rd_state_t             state;
  logic [PW_W-1:0]       pw_cnt;
  logic [CNT_W-1:0]      bit_cnt, bit_nxt, len_q, len_eff;
  logic                  pub_pend;
  logic                  tick;
  logic [1:0]            sdo_sync;
  logic                  sdo_s;
  logic                  start_frame, shift_now;
  logic [FRAME_BITS-1:0] sh_data;

  always_ff @(posedge clk) begin
    if (rst) sdo_sync <= 2'b11;
    else     sdo_sync <= {sdo_sync[0], sdo_i};
  end
  assign sdo_s = sdo_sync[1];

  sfr_tick #(.DIV_W(DIV_W), .MIN_HALF(MIN_HALF), .DEF_HALF(DEF_HALF)) i_tick (
    .clk(clk), .rst(rst), .half_i(half_period_i), .tick_o(tick));

  assign start_frame = (state == ST_POLL) && tick && !sdo_s;
  assign shift_now   = (state == ST_HI) && tick;
  assign bit_nxt     = bit_cnt + 1'b1;

  always_comb begin
    if (frame_len_i == '0 || frame_len_i >= LEN_W'(FRAME_BITS)) len_eff = CNT_W'(FRAME_BITS);
    else                                                         len_eff = CNT_W'(frame_len_i);
  end

  sfr_shift #(.W(FRAME_BITS)) i_shift (
    .clk(clk), .rst(rst), .clr_i(start_frame), .en_i(shift_now),
    .bit_i(sdo_s), .data_o(sh_data));

  always_ff @(posedge clk) begin
    if (rst) begin
      state          <= ST_PWRUP;
      pw_cnt         <= '0;
      sck_o          <= 1'b0;
      bit_cnt        <= '0;
      len_q          <= CNT_W'(FRAME_BITS);
      pub_pend       <= 1'b0;
      result_valid_o <= 1'b0;
      frame_o        <= '0;
      eoc_err_o      <= 1'b0;
    end else begin
      result_valid_o <= 1'b0;
      pub_pend       <= 1'b0;
      if (pub_pend) begin
        frame_o        <= sh_data << (CNT_W'(FRAME_BITS) - len_q);
        result_valid_o <= 1'b1;
      end
      case (state)
        ST_PWRUP: begin
          if (pw_cnt == PW_W'(PWRUP_CYCLES - 1)) state <= ST_POLL;
          else                                   pw_cnt <= pw_cnt + 1'b1;
        end
        ST_POLL: begin
          if (start_frame) begin
            sck_o   <= 1'b1;
            bit_cnt <= '0;
            len_q   <= len_eff;
            state   <= ST_HI;
          end
        end
        ST_HI: begin
          if (tick) begin
            sck_o   <= 1'b0;
            bit_cnt <= bit_nxt;
            if (bit_cnt == '0 && sdo_s) eoc_err_o <= 1'b1;
            if (bit_nxt == len_q)       pub_pend  <= 1'b1;
            state <= (bit_nxt == CNT_W'(FRAME_BITS)) ? ST_POLL : ST_LO;
          end
        end
        default: begin
          if (tick) begin
            sck_o <= 1'b1;
            state <= ST_HI;
          end
        end
      endcase
    end
  end

  assign status_o = frame_o[FRAME_BITS-1 -: STAT_BITS];
  assign result_o = frame_o[RES_BITS-1:0];

  // R1
  pwrup_low_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_PWRUP) |-> !sck_o);
  // R2
  idle_high_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_POLL && sdo_s) |=> !sck_o);
  // R3
  sck_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(sck_o));
  // R5
  bit_range_chk: assert property (@(posedge clk) disable iff (rst)
    bit_cnt <= CNT_W'(FRAME_BITS));
  // R6
  valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    result_valid_o |=> !result_valid_o);
  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    eoc_err_o |=> eoc_err_o);
endmodule

// File: tb/test_sdo_frame_reader.sv
module test_sdo_frame_reader;
  localparam int PW = 200;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sdo = 1'b0;
  logic [7:0]  half_p = 8'd6;
  logic [4:0]  flen = 5'd0;
  logic        sck;
  logic [23:0] frame;
  logic [3:0]  status;
  logic [19:0] result;
  logic        valid, err;

  int tests = 0, fails = 0;
  int cyc = 0, rise_cnt = 0, since_fall = 0, pushed = 0, popped = 0;
  logic sck_prev = 1'b0;
  logic [24:0] exp_q[$];

  always #4 clk = ~clk;

  sdo_frame_reader #(.PWRUP_CYCLES(PW)) i_sdo_frame_reader (
    .clk(clk), .rst(rst), .sdo_i(sdo), .half_period_i(half_p), .frame_len_i(flen),
    .sck_o(sck), .frame_o(frame), .status_o(status), .result_o(result),
    .result_valid_o(valid), .eoc_err_o(err));

  always @(posedge clk) cyc <= cyc + 1;
  always @(posedge sck) rise_cnt <= rise_cnt + 1;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard on each strobe
  always @(negedge clk) begin
    if (sck_prev && !sck) since_fall = 0;
    else                  since_fall++;
    sck_prev = sck;
    if (!rst && valid) begin
      if (exp_q.size() == 0) check(1'b0, "R6 unexpected strobe", 32'(frame), 0);
      else begin
        logic [24:0] e;
        e = exp_q.pop_front();
        popped++;
        check(frame == e[23:0], "R4/R7 frame", 32'(frame), 32'(e[23:0]));
        check(status == e[23:20] && result == e[19:0], "R6 fields", 32'({status, result}), 32'(e[23:0]));
        check(err == e[24], "R8 error flag", 32'(err), 32'(e[24]));
        check(since_fall == 1, "R9 strobe timing", 32'(since_fall), 1);
      end
    end
  end

  task automatic send(input logic [23:0] f, input bit bad, input logic [7:0] hp,
                      input logic [4:0] len, input bit exp_err);
    int h, l, t0;
    logic [23:0] m;
    half_p = hp;
    flen = len;
    h = (hp == 0) ? 32 : (hp < 4) ? 4 : int'(hp);
    l = (len == 0 || len >= 24) ? 24 : int'(len);
    m = (f >> (24 - l)) << (24 - l);
    sdo = 1'b1;
    repeat (60) @(posedge clk);
    exp_q.push_back({exp_err, m});
    pushed++;
    rise_cnt = 0;
    sdo = 1'b0;
    for (int i = 23; i >= 0; i--) begin
      @(posedge sck); #1;
      if (i == 23) t0 = cyc;
      if (i == 23 && bad) sdo = 1'b1;
      @(negedge sck); #1;
      if (i == 23) check(cyc - t0 == h, "R3 half period", 32'(cyc - t0), 32'(h));
      sdo = (i > 0) ? f[i-1] : 1'b1;
    end
    repeat (3) @(posedge clk);
    check(rise_cnt == 24, "R5/R7 pulse count", 32'(rise_cnt), 24);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check(!sck && !valid && !err, "R1 reset state", 32'({sck, valid, err}), 0);
    rise_cnt = 0;
    repeat (150) @(posedge clk);
    #1 check(rise_cnt == 0, "R1 no pulse during power-up wait", 32'(rise_cnt), 0);
    sdo = 1'b1;
    repeat (300) @(posedge clk);
    #1 check(rise_cnt == 0 && popped == 0, "R2 idle while line high", 32'(rise_cnt), 0);

    send(24'h3ABCDE, 0, 8'd6, 5'd0,  0);
    send(24'h012345, 0, 8'd2, 5'd24, 0);
    send(24'h5F0F0F, 0, 8'd5, 5'd10, 0);
    send(24'h7FFFFF, 0, 8'd4, 5'd1,  0);
    send(24'h155555, 0, 8'd0, 5'd31, 0);
    send(24'hC00001, 1, 8'd4, 5'd0,  1);
    send(24'h2AAAAA, 0, 8'd9, 5'd23, 1);

    sdo = 1'b1;
    repeat (40) @(posedge clk);
    #1 check(popped == pushed && exp_q.size() == 0, "R6 one strobe per frame", 32'(popped), 32'(pushed));
    check(rise_cnt == 24, "R2 no pulses after final frame", 32'(rise_cnt), 24);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule